// File: doc/BRIEF.md
# Relocatable On-Chip Register Window Decoder

This block sits between a processor's I/O cycle signals and the external bus. For every I/O cycle it decides whether the access lands in a 64-location on-chip register window or goes out to external devices. When the window is hit, the block asserts an internal select and gives the 6-bit register offset. It also holds back the external read and write strobes, so no outside device sees the cycle.

The window can sit at one of four aligned 64-port places in the low 256-port page. A relocation register inside the window picks the place. The window only answers when the upper address byte is zero, so every other I/O address stays free for external hardware. Special internal-access instructions can force the upper byte to zero through a dedicated input. The bus here is a cycle-qualified strobe bus with no flow control. Every pin is a plain control or data pin, and no valid/ready interface applies.

Top module: `io_window_decode`

## Requirements
- R1: After reset the window base is 00h, so an I/O cycle at address 0005h selects the window.
- R2: An I/O cycle whose effective upper address byte is not 00h never selects the window, and it asserts ext_en.
- R3: The window covers only the 64 ports from its base; with base 00h, port 0045h goes to the external bus.
- R4: While force_hi_zero is high the upper address byte is treated as 00h, so address 1205h at base 00h selects the window.
- R5: reg_ofs equals io_addr[5:0] while int_sel is high, and it is 0 otherwise.
- R6: While int_sel is high, ext_rd and ext_wr are low. On a miss, ext_rd follows io_rd and ext_wr follows io_wr.
- R7: When cyc_io is low (a memory cycle), int_sel and ext_en are low for any address.
- R8: The relocation register is at window offset 3Fh. A write there loads bits 7:6 of wr_data as the new base. The new base takes effect only after cyc_io has been low for one clock, so the current cycle keeps the old base.
- R9: Reading window offset 3Fh returns {base, 6'b0} on rd_data; every other cycle returns 00h.
- R10: Each of the bases 00h, 40h, 80h and C0h can be selected, and the window then answers at base+00h through base+3Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_io | input | 1 | High during an I/O cycle, low for memory cycles |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| force_hi_zero | input | 1 | Treat upper address byte as zero |
| wr_data | input | 8 | Write data |
| int_sel | output | 1 | Cycle targets the on-chip window |
| reg_ofs | output | 6 | Register offset within the window |
| ext_en | output | 1 | Cycle goes to the external bus |
| ext_rd | output | 1 | Gated external read strobe |
| ext_wr | output | 1 | Gated external write strobe |
| rd_data | output | 8 | Relocation register read value |

## Verification
The bench moves the window to each of the four bases and probes the ports just inside and just outside each one. A base compare that is off by one bit would show up there as a hit at the wrong place. It writes the relocation register and checks that the same cycle still decodes at the old base. A design that applied the new base at once would drop the select partway through the cycle. It also sends addresses with a nonzero upper byte, with and without the force input, and drives memory cycles. A design that ignored the upper byte or the cycle type would show a stray internal select, or would leak strobes onto the external bus.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  parameter int ADDR_W   = 16;
  parameter int DATA_W   = 8;
  parameter int OFS_W    = 6;
  parameter int BASE_W   = 2;
  localparam int PAGE_W  = OFS_W + BASE_W;
  localparam int HI_W    = ADDR_W - PAGE_W;
  localparam logic [OFS_W-1:0] RELOC_OFS = {OFS_W{1'b1}};
  localparam logic [BASE_W-1:0] BASE_RST = '0;

  typedef struct packed {
    logic             hit;
    logic             miss;
    logic [OFS_W-1:0] ofs;
  } dec_t;
endpackage

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
(
  input  logic              cyc_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic              force_hi_zero,
  input  logic [BASE_W-1:0] base,
  output dec_t              dec
);
  logic [HI_W-1:0] hi_eff;
  logic            page_ok;
  logic            slot_ok;

  always_comb begin
    hi_eff   = force_hi_zero ? '0 : addr[ADDR_W-1:PAGE_W];
    page_ok  = (hi_eff == '0);
    slot_ok  = (addr[PAGE_W-1:OFS_W] == base);
    dec.hit  = cyc_io & page_ok & slot_ok;
    dec.miss = cyc_io & ~dec.hit;
    dec.ofs  = dec.hit ? addr[OFS_W-1:0] : '0;
  end
endmodule

// File: rtl/iowin_reloc.sv
module iowin_reloc
  import iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_io,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BASE_W-1:0] base,
  output logic [DATA_W-1:0] rd_data
);
  logic              pend_q;
  logic [BASE_W-1:0] pend_val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base       <= BASE_RST;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (wr_hit) begin
      pend_q     <= 1'b1;
      pend_val_q <= wr_data[DATA_W-1 -: BASE_W];
    end else if (!cyc_io && pend_q) begin
      base   <= pend_val_q;
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data[DATA_W-1 -: BASE_W] = base;
  end
endmodule

// File: rtl/iowin_gate.sv
module iowin_gate
  import iowin_pkg::*;
(
  input  dec_t dec,
  input  logic io_rd,
  input  logic io_wr,
  output logic ext_en,
  output logic ext_rd,
  output logic ext_wr
);
  always_comb begin
    ext_en = dec.miss;
    ext_rd = io_rd & ~dec.hit;
    ext_wr = io_wr & ~dec.hit;
  end
endmodule

// File: rtl/io_window_decode.sv
module io_window_decode
  import iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_io,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              force_hi_zero,
  input  logic [DATA_W-1:0] wr_data,
  output logic              int_sel,
  output logic [OFS_W-1:0]  reg_ofs,
  output logic              ext_en,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [DATA_W-1:0] rd_data
);
  dec_t              dec;
  logic [BASE_W-1:0] win_base;
  logic              reloc_at;

  iowin_match u_match (
    .cyc_io(cyc_io), .addr(io_addr), .force_hi_zero(force_hi_zero),
    .base(win_base), .dec(dec)
  );

  assign reloc_at = dec.hit & (dec.ofs == RELOC_OFS);

  iowin_reloc u_reloc (
    .clk(clk), .rst_n(rst_n), .cyc_io(cyc_io),
    .wr_hit(reloc_at & io_wr), .rd_hit(reloc_at & io_rd),
    .wr_data(wr_data), .base(win_base), .rd_data(rd_data)
  );

  iowin_gate u_gate (
    .dec(dec), .io_rd(io_rd), .io_wr(io_wr),
    .ext_en(ext_en), .ext_rd(ext_rd), .ext_wr(ext_wr)
  );

  assign int_sel = dec.hit;
  assign reg_ofs = dec.ofs;
endmodule

// File: rtl/io_window_decode_chk.sv
module io_window_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_io,
  input logic [15:0] io_addr,
  input logic        force_hi_zero,
  input logic        int_sel,
  input logic [5:0]  reg_ofs,
  input logic        ext_en,
  input logic        ext_rd,
  input logic        ext_wr,
  input logic [1:0]  win_base
);
  AST_MEM_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_io |-> (!int_sel && !ext_en)); // R7
  AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> (!ext_rd && !ext_wr)); // R6
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sel && !force_hi_zero) |-> (io_addr[15:8] == 8'h00)); // R2
  AST_OFS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> (reg_ofs == io_addr[5:0])); // R5
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_io && $past(cyc_io)) |-> $stable(win_base)); // R8
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_sel && ext_en)); // R2
endmodule

bind io_window_decode io_window_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_io(cyc_io), .io_addr(io_addr),
  .force_hi_zero(force_hi_zero), .int_sel(int_sel), .reg_ofs(reg_ofs),
  .ext_en(ext_en), .ext_rd(ext_rd), .ext_wr(ext_wr), .win_base(win_base)
);

// File: tb/io_window_decode_test.sv
`timescale 1ns/1ps
module io_window_decode_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cyc_io = 0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 0, io_wr = 0, force_hi_zero = 0;
  logic [7:0]  wr_data = '0;
  logic        int_sel, ext_en, ext_rd, ext_wr;
  logic [5:0]  reg_ofs;
  logic [7:0]  rd_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  io_window_decode uut (
    .clk(clk), .rst_n(rst_n), .cyc_io(cyc_io), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .force_hi_zero(force_hi_zero),
    .wr_data(wr_data), .int_sel(int_sel), .reg_ofs(reg_ofs),
    .ext_en(ext_en), .ext_rd(ext_rd), .ext_wr(ext_wr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cyc_io = 0; io_rd = 0; io_wr = 0; force_hi_zero = 0;
    @(negedge clk);
  endtask

  task automatic start_io(input logic [15:0] a, input logic rd, input logic wr,
                          input logic fz, input logic [7:0] d);
    @(negedge clk);
    cyc_io = 1; io_addr = a; io_rd = rd; io_wr = wr; force_hi_zero = fz; wr_data = d;
    #1;
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic exp_hit);
    start_io(a, 1'b1, 1'b0, 1'b0, 8'h00);
    chk(req, int_sel, exp_hit);
    chk(req, ext_en, !exp_hit);
    chk(req, ext_rd, !exp_hit);
    chk(req, reg_ofs, exp_hit ? a[5:0] : 6'd0);
    idle();
  endtask

  task automatic set_base(input logic [1:0] b, input logic [7:0] cur);
    start_io({8'h00, cur[7:6], 6'h3F}, 1'b0, 1'b1, 1'b0, {b, 6'h15});
    chk("R8", int_sel, 1'b1);
    chk("R6", ext_wr, 1'b0);
    @(negedge clk); #1;
    chk("R8", int_sel, 1'b1);
    idle();
  endtask

  task automatic t_reset();
    chk("R1", int_sel, 0); chk("R7", ext_en, 0);
    probe("R1", 16'h0005, 1);
    probe("R3", 16'h0045, 0);
    probe("R2", 16'h0105, 0);
  endtask

  task automatic t_force();
    start_io(16'h1205, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R4", int_sel, 1); chk("R6", ext_wr, 0); chk("R5", reg_ofs, 6'h05);
    idle();
    start_io(16'h1205, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R2", int_sel, 0); chk("R6", ext_wr, 1);
    idle();
  endtask

  task automatic t_mem();
    @(negedge clk);
    cyc_io = 0; io_addr = 16'h0005; io_rd = 1; #1;
    chk("R7", int_sel, 0); chk("R7", ext_en, 0); chk("R5", reg_ofs, 0);
    idle();
  endtask

  task automatic t_bases();
    logic [7:0] cur = 8'h00;
    for (int b = 3; b >= 0; b--) begin
      set_base(b[1:0], cur);
      cur = {b[1:0], 6'h00};
      probe("R10", {8'h00, cur}, 1);
      probe("R10", {8'h00, cur | 8'h3F}, 1);
      probe("R10", {8'h00, cur ^ 8'h40}, 0);
      probe("R2", {8'h01, cur}, 0);
      start_io({8'h00, cur | 8'h3F}, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R9", rd_data, cur);
      idle();
      start_io({8'h00, cur | 8'h3E}, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R9", rd_data, 8'h00);
      idle();
    end
  endtask

  task automatic t_hold();
    set_base(2'b10, 8'h00);
    probe("R8", 16'h0005, 0);
    probe("R8", 16'h0085, 1);
    set_base(2'b00, 8'h80);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    t_force();
    t_mem();
    t_hold();
    t_bases();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule